// File: doc/BRIEF.md
# AC97 Slot-Gated Transmit Framer

This block produces the outgoing serial frames of an AC97 link, one bit per bit clock. It runs the frame timing itself. It raises the frame-sync output during the tag slot. In each frame it fills the output data slots that software has enabled with words taken from a first-word-fall-through transmit FIFO, and it sends them MSB first. It also watches the incoming serial line during slot 1 and keeps the codec's per-slot request bits for use in the following frame.

A frame carries either data for all of its enabled slots or no data at all. Data is withheld from the whole frame, and no FIFO word is consumed, in three cases: the codec's previous slot-request word marks any enabled slot as not wanted, the FIFO holds fewer words than the frame needs, or no slot is enabled. Because a frame is never sent with only some of its enabled slots filled, the words keep their FIFO order across the output slots. The enabled mask, the request bits and the FIFO level are all sampled once, on the last bit clock of the previous frame.

Top module: `ac97_tx_framer`

## Requirements
- R1: A frame is 256 bit clocks long: a 16-bit tag slot (slot 0) followed by twelve 20-bit slots (1 to 12). `sync` is high for exactly the 16 bit clocks of slot 0 and low for the other 240.
- R2: The tag is sent MSB first. Tag bit 15 is the frame-valid bit. Tag bit 15-k is the valid bit of slot k. Bits 2..0 are zero. In a frame that carries data, bit 15 is 1 and slot k's bit is 1 exactly when slot k is enabled. In an empty frame all 16 tag bits are 0.
- R3: In a frame that carries data, each enabled slot k (3 to 12) carries one FIFO word, MSB first, and the words go into the enabled slots in ascending slot order and in FIFO order. Slots 1 and 2, disabled slots and every slot of an empty frame are all zeros.
- R4: If a request bit captured in the previous frame is 1 for any enabled slot, the frame is empty and no word is popped. The words that were not sent stay at the head of the FIFO and go out in a later frame.
- R5: Request bits are captured from bits 11 down to 2 of incoming slot 1 (bit 11 is slot 3 and bit 2 is slot 12, so bit b belongs to slot 14-b). Slot-1 bits 19 to 12 and 1 to 0, all other incoming slots, and request bits of slots that are not enabled have no effect.
- R6: If `fifo_level` on the last bit clock of the previous frame is below the number of enabled slots, the frame is empty and no word is popped.
- R7: A frame that carries data pops exactly one word per enabled slot. Each `fifo_pop` pulse lasts one bit clock and falls on the last bit clock of the slot before the one the word fills. An empty frame pops nothing.
- R8: `slot_en` (bit i enables slot i+3) is sampled only on the last bit clock of the previous frame, so changes during a frame have no effect on that frame. An all-zero mask gives an empty frame.
- R9: While reset is held, and on the first bit clock after it is released, the block outputs slot 0 bit 15 with `sync` high, `sdata_out` low and `fifo_pop` low. The first frame after reset is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_en | input | 10 | Transmit slot enable; bit i enables slot i+3 |
| sdata_in | input | 1 | Incoming serial data from the codec, sampled on the rising edge |
| fifo_rd_data | input | 20 | Head word of the transmit FIFO (first-word-fall-through) |
| fifo_level | input | 5 | Number of words currently held in the transmit FIFO |
| fifo_pop | output | 1 | One-clock pulse that consumes the head word |
| sync | output | 1 | Frame sync, high during slot 0 |
| sdata_out | output | 1 | Outgoing serial data |

## Verification
The assertions assume a FIFO that behaves as first-word-fall-through. `fifo_level` must count the words that `fifo_rd_data` can deliver, and between frame decisions it must fall only by the pops this block issues, so a pop never finds an empty FIFO. They also assume that `sdata_in` and `slot_en` settle well clear of the rising edge. The bench keeps to these assumptions. Its FIFO model pushes words only at bit 240 of a frame, after the last pop of that frame, and removes a word only after the edge that pops it. All inputs are driven on falling edges, and the slot mask is scrambled during each frame and set to its real value before the decision edge.

// File: rtl/ac97_tx_pkg.sv
// Package: shared frame geometry of the AC97 transmit framer.
// Assumes the standard 16-bit tag slot plus twelve 20-bit slots.
package ac97_tx_pkg;
    localparam int TAG_BITS   = 16;  // bits in slot 0
    localparam int SLOT_BITS  = 20;  // bits in slots 1..12
    localparam int LAST_SLOT  = 12;  // index of the final slot
    localparam int FIRST_DATA = 3;   // lowest slot that carries FIFO data
    localparam int DATA_SLOTS = LAST_SLOT - FIRST_DATA + 1;
    localparam int REQ_SLOT   = 1;   // incoming slot holding request bits
    localparam int REQ_MSB    = 11;  // request bit of FIRST_DATA within REQ_SLOT
    localparam int LEVEL_W    = 5;   // width of the FIFO level input
endpackage

// File: rtl/ac97_frame_timer.sv
// Module: ac97_frame_timer
// Counts slots and bits inside a frame and drives frame sync.
// Assumes slot 0 is TAG_W bits and the other NSLOT slots are SLOT_W bits.
module ac97_frame_timer #(
    parameter int TAG_W  = 16,
    parameter int SLOT_W = 20,
    parameter int NSLOT  = 12,
    parameter int SL_W   = $clog2(NSLOT + 1),
    parameter int SB_W   = $clog2((TAG_W > SLOT_W) ? TAG_W : SLOT_W)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [SL_W-1:0] slot_q,
    output logic [SB_W-1:0] sbit_q,
    output logic            slot_last,
    output logic            frame_last,
    output logic            sync
);
    localparam logic [SL_W-1:0] SLOT_END = SL_W'(NSLOT);
    localparam logic [SB_W-1:0] TAG_END  = SB_W'(TAG_W - 1);
    localparam logic [SB_W-1:0] DAT_END  = SB_W'(SLOT_W - 1);

    // Purpose: flag the last bit of the current slot and of the frame.
    always_comb begin
        slot_last  = (slot_q == '0) ? (sbit_q == TAG_END) : (sbit_q == DAT_END);
        frame_last = slot_last && (slot_q == SLOT_END);
        sync       = (slot_q == '0);
    end

    // Purpose: advance the bit and slot counters, wrapping at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            sbit_q <= '0;
        end else if (slot_last) begin
            sbit_q <= '0;
            slot_q <= frame_last ? '0 : slot_q + 1'b1;
        end else begin
            sbit_q <= sbit_q + 1'b1;
        end
    end

    p_tag_to_slot1_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == '0 && sbit_q == TAG_END) |=> (slot_q == SL_W'(1) && sbit_q == '0))
        else $error("slot 0 did not end after TAG_W bits");
    p_frame_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_last |=> (slot_q == '0 && sbit_q == '0))
        else $error("frame did not wrap to slot 0");
    p_sync_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync) |-> $past(frame_last))
        else $error("sync rose away from a frame boundary");
    p_slot_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q <= SLOT_END)
        else $error("slot counter out of range");
endmodule

// File: rtl/ac97_req_capture.sv
// Module: ac97_req_capture
// Samples the codec's slot-request bits from the incoming request slot.
// Assumes request bits arrive MSB first, the first-transmitted one belonging
// to the lowest data slot; the result holds until the same window next frame.
module ac97_req_capture #(
    parameter int NREQ     = 10,
    parameter int SLOT_W   = 20,
    parameter int REQ_SLOT = 1,
    parameter int REQ_MSB  = 11,
    parameter int SL_W     = 4,
    parameter int SB_W     = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SL_W-1:0] slot_q,
    input  logic [SB_W-1:0] sbit_q,
    input  logic            sdata_in,
    output logic [NREQ-1:0] req_mask
);
    localparam logic [SB_W-1:0] WIN_LO = SB_W'(SLOT_W - 1 - REQ_MSB);
    localparam logic [SB_W-1:0] WIN_HI = SB_W'(SLOT_W - 1 - REQ_MSB + NREQ - 1);

    logic in_window;

    // Purpose: decode the bit positions that carry request flags.
    always_comb begin
        in_window = (slot_q == SL_W'(REQ_SLOT)) && (sbit_q >= WIN_LO) && (sbit_q <= WIN_HI);
    end

    // Purpose: shift request bits in so bit i ends up as the flag of data slot i.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_mask <= '0;
        end else if (in_window) begin
            req_mask <= {sdata_in, req_mask[NREQ-1:1]};
        end
    end

    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_window |=> $stable(req_mask))
        else $error("request mask changed outside its capture window");
    p_req_slot_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q != SL_W'(REQ_SLOT)) |=> $stable(req_mask))
        else $error("request mask changed outside the request slot");
endmodule

// File: rtl/ac97_slot_gate.sv
// Module: ac97_slot_gate
// Makes the once-per-frame all-or-nothing decision and holds it with the
// enable mask for the frame about to start.
// Assumes fifo_level only shrinks through this block's own pops.
module ac97_slot_gate #(
    parameter int NREQ  = 10,
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_last,
    input  logic [NREQ-1:0]  slot_en,
    input  logic [NREQ-1:0]  req_mask,
    input  logic [LVL_W-1:0] fifo_level,
    output logic             go_q,
    output logic [NREQ-1:0]  en_q
);
    int   needed;
    logic blocked;
    logic starved;
    logic go_d;

    // Purpose: a frame carries data only if every enabled slot can be filled.
    always_comb begin
        needed  = $countones(slot_en);
        blocked = |(slot_en & req_mask);
        starved = int'(fifo_level) < needed;
        go_d    = (needed != 0) && !blocked && !starved;
    end

    // Purpose: latch the decision and the mask at the frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_q <= 1'b0;
            en_q <= '0;
        end else if (frame_last) begin
            go_q <= go_d;
            en_q <= slot_en;
        end
    end

    p_req_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_last && |(slot_en & req_mask)) |=> !go_q)
        else $error("frame sent although an enabled slot was refused");
    p_starve_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_last && (int'(fifo_level) < $countones(slot_en))) |=> !go_q)
        else $error("frame sent without enough FIFO words");
    p_mask_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_last |=> ($stable(go_q) && $stable(en_q)))
        else $error("frame decision changed mid-frame");
    p_zero_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_last && slot_en == '0) |=> !go_q)
        else $error("frame marked valid with no slot enabled");
endmodule

// File: rtl/ac97_tx_framer.sv
// Module: ac97_tx_framer (top)
// Serialises AC97 output frames: the tag in slot 0, then FIFO words in the
// enabled data slots, MSB first. It pops the FIFO one slot ahead of use.
// Assumes a first-word-fall-through FIFO whose level counts readable words.
module ac97_tx_framer
    import ac97_tx_pkg::*;
#(
    parameter int TAG_W  = TAG_BITS,
    parameter int SLOT_W = SLOT_BITS,
    parameter int NSLOT  = LAST_SLOT,
    parameter int FIRST  = FIRST_DATA,
    parameter int NREQ   = DATA_SLOTS,
    parameter int LVL_W  = LEVEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREQ-1:0]   slot_en,
    input  logic              sdata_in,
    input  logic [SLOT_W-1:0] fifo_rd_data,
    input  logic [LVL_W-1:0]  fifo_level,
    output logic              fifo_pop,
    output logic              sync,
    output logic              sdata_out
);
    localparam int SL_W  = $clog2(NSLOT + 1);
    localparam int SB_W  = $clog2((TAG_W > SLOT_W) ? TAG_W : SLOT_W);
    localparam int EI_W  = $clog2(NREQ);
    localparam int TI_W  = $clog2(TAG_W);
    localparam int WI_W  = $clog2(SLOT_W);
    localparam int CNT_W = $clog2(NREQ + 1);

    logic [SL_W-1:0]   slot_q;
    logic [SB_W-1:0]   sbit_q;
    logic              slot_last;
    logic              frame_last;
    logic [NREQ-1:0]   req_mask;
    logic              go_q;
    logic [NREQ-1:0]   en_q;
    logic [TAG_W-1:0]  tag_vec;
    logic [SLOT_W-1:0] word_q;
    logic [CNT_W-1:0]  pop_cnt;

    ac97_frame_timer #(
        .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NSLOT(NSLOT), .SL_W(SL_W), .SB_W(SB_W)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .slot_q(slot_q), .sbit_q(sbit_q),
        .slot_last(slot_last), .frame_last(frame_last), .sync(sync)
    );

    ac97_req_capture #(
        .NREQ(NREQ), .SLOT_W(SLOT_W), .REQ_SLOT(REQ_SLOT), .REQ_MSB(REQ_MSB),
        .SL_W(SL_W), .SB_W(SB_W)
    ) u_req (
        .clk(clk), .rst_n(rst_n), .slot_q(slot_q), .sbit_q(sbit_q),
        .sdata_in(sdata_in), .req_mask(req_mask)
    );

    ac97_slot_gate #(
        .NREQ(NREQ), .LVL_W(LVL_W)
    ) u_gate (
        .clk(clk), .rst_n(rst_n), .frame_last(frame_last), .slot_en(slot_en),
        .req_mask(req_mask), .fifo_level(fifo_level), .go_q(go_q), .en_q(en_q)
    );

    // Purpose: tag word, with the frame-valid bit on top and one bit per data slot.
    always_comb begin
        tag_vec            = '0;
        tag_vec[TAG_W - 1] = go_q;
        for (int i = 0; i < NREQ; i++) begin
            tag_vec[TAG_W - 1 - FIRST - i] = go_q & en_q[i];
        end
    end

    // Purpose: request the word for the next slot on this slot's last bit.
    always_comb begin
        int nidx;
        nidx     = int'(slot_q) - (FIRST - 1);
        fifo_pop = 1'b0;
        if (slot_last && go_q && nidx >= 0 && nidx < NREQ) begin
            fifo_pop = en_q[nidx[EI_W-1:0]];
        end
    end

    // Purpose: hold the word being sent in the current data slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (fifo_pop) begin
            word_q <= fifo_rd_data;
        end
    end

    // Purpose: select the serial output bit for the current position.
    always_comb begin
        int didx;
        int tpos;
        int wpos;
        didx      = int'(slot_q) - FIRST;
        tpos      = TAG_W - 1 - int'(sbit_q);
        wpos      = SLOT_W - 1 - int'(sbit_q);
        sdata_out = 1'b0;
        if (slot_q == '0) begin
            sdata_out = tag_vec[tpos[TI_W-1:0]];
        end else if (didx >= 0 && didx < NREQ) begin
            if (go_q && en_q[didx[EI_W-1:0]]) begin
                sdata_out = word_q[wpos[WI_W-1:0]];
            end
        end
    end

    // Purpose: count pops in the current frame for the pop-count check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_cnt <= '0;
        end else if (frame_last) begin
            pop_cnt <= '0;
        end else if (fifo_pop) begin
            pop_cnt <= pop_cnt + 1'b1;
        end
    end

    p_pop_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_last |-> (int'(pop_cnt) == (go_q ? $countones(en_q) : 0)))
        else $error("pop count does not match the enabled slots");
    p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (fifo_level != '0))
        else $error("pop issued on an empty FIFO");
    p_pop_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> !fifo_pop)
        else $error("pop lasted more than one bit clock");
    p_word_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_pop |=> $stable(word_q))
        else $error("data word changed without a pop");
    p_idle_slots_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == SL_W'(1) || slot_q == SL_W'(2)) |-> !sdata_out)
        else $error("data driven in a command slot");
    p_empty_no_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !go_q |-> !fifo_pop)
        else $error("pop issued during an empty frame");
endmodule

// File: tb/ac97_tx_framer_tb.sv
// Scoreboard bench: the driver builds the expected frame and pushes it into a
// queue; the monitor collects each frame from the outputs and compares it.
module ac97_tx_framer_tb;
    localparam int NF = 12;     // frames in the run
    localparam int FB = 256;    // bit clocks per frame

    typedef struct {
        logic [FB-1:0] bits;
        int            pops;
        string         tag;
    } frame_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  slot_en = '0;
    logic        sdata_in = 1'b0;
    logic [19:0] fifo_rd_data = '0;
    logic [4:0]  fifo_level = '0;
    logic        fifo_pop;
    logic        sync;
    logic        sdata_out;

    logic [19:0] fq[$];
    frame_t      expq[$];
    int          n_run = 0;
    int          n_fail = 0;
    int          wcnt = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    ac97_tx_framer u_dut (
        .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .sdata_in(sdata_in),
        .fifo_rd_data(fifo_rd_data), .fifo_level(fifo_level),
        .fifo_pop(fifo_pop), .sync(sync), .sdata_out(sdata_out)
    );

    // Per-frame stimulus plan (frame 0 follows reset and is always empty).
    function automatic logic [9:0] en_plan(int f);
        case (f)
            1, 2, 3: return 10'h003;
            4, 5:    return 10'h213;
            6:       return 10'h3FF;
            8:       return 10'h001;
            9, 10:   return 10'h200;
            11:      return 10'h00C;
            default: return 10'h000;
        endcase
    endfunction

    function automatic int push_plan(int f);
        case (f)
            1, 2, 11:  return 2;
            4:         return 3;
            5, 8, 9:   return 1;
            6:         return 10;
            default:   return 0;
        endcase
    endfunction

    function automatic logic [9:0] req_plan(int f);
        case (f)
            2:       return 10'h002;
            5:       return 10'h004;
            8, 9:    return 10'h200;
            11:      return 10'h001;
            default: return 10'h000;
        endcase
    endfunction

    function automatic string tag_plan(int f);
        case (f)
            1:         return "R7";
            2, 3:      return "R4";
            4:         return "R6";
            5, 8, 9, 11: return "R5";
            7:         return "R8";
            default:   return "R3";
        endcase
    endfunction

    task automatic fifo_sync();
        fifo_level   = 5'(fq.size());
        fifo_rd_data = (fq.size() != 0) ? fq[0] : 20'h0;
    endtask

    task automatic check(bit ok, string req, string what, logic [255:0] got, logic [255:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // Driver task: fill the FIFO model for frame f and queue its expected frame.
    task automatic plan_frame(int f);
        frame_t e;
        logic [9:0] en;
        int need;
        int k;
        bit ok;
        en = en_plan(f);
        for (int n = 0; n < push_plan(f); n++) begin
            wcnt++;
            fq.push_back(20'(wcnt * 32'h4F1B) ^ 20'hA5A5A);
        end
        fifo_sync();
        slot_en = en;
        need = $countones(en);
        ok = (f != 0) && (need != 0) && ((en & req_plan(f)) == 0) && (fq.size() >= need);
        e.bits = '0;
        e.pops = ok ? need : 0;
        e.tag  = tag_plan(f);
        e.bits[0] = ok;
        k = 0;
        for (int s = 1; s <= 12; s++) begin
            if (ok && s >= 3 && en[s-3]) begin
                e.bits[s] = 1'b1;
                for (int j = 0; j < 20; j++) e.bits[16 + 20*(s-1) + j] = fq[k][19-j];
                k++;
            end
        end
        expq.push_back(e);
    endtask

    // Driver: reset, then per bit clock drive sdata_in, scramble and set the mask.
    initial begin
        plan_frame(0);
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int f = 0; f < NF; f++) begin
            for (int b = 0; b < FB; b++) begin
                @(negedge clk);
                if (b >= 24 && b <= 33) sdata_in = req_plan(f + 1)[b - 24];
                else if (b >= 16 && b <= 35) sdata_in = 1'b1;   // non-request bits of slot 1
                else sdata_in = b[0];
                if (b == 20) slot_en = ~en_plan(f);               // R8: mid-frame change
                if (b == 240 && f + 1 < NF) plan_frame(f + 1);
            end
        end
    end

    // Monitor: FIFO pop model, output capture and per-frame comparison.
    initial begin
        logic [FB-1:0] got_d;
        logic [FB-1:0] got_s;
        logic [FB-1:0] exp_s;
        int   pops;
        bit   pend;
        frame_t e;
        pend = 1'b0;
        @(negedge clk);
        check(sync === 1'b1 && sdata_out === 1'b0 && fifo_pop === 1'b0, "R9", "reset outputs",
              256'({sync, sdata_out, fifo_pop}), 256'(3'b100));
        wait (rst_n);
        exp_s = '0;
        exp_s[15:0] = '1;
        for (int f = 0; f < NF; f++) begin
            pops = 0;
            for (int b = 0; b < FB; b++) begin
                @(negedge clk);
                if (pend) begin
                    if (fq.size() == 0) check(1'b0, "R6", "pop from empty FIFO", 256'(0), 256'(1));
                    else void'(fq.pop_front());
                    fifo_sync();
                end
                pend = fifo_pop;
                if (fifo_pop) pops++;
                got_d[b] = sdata_out;
                got_s[b] = sync;
            end
            e = expq.pop_front();
            if (f == 0) begin
                check(got_d == '0 && pops == 0, "R9", "first frame after reset", got_d, '0);
            end
            check(got_s == exp_s, "R1", $sformatf("frame %0d sync", f), got_s, exp_s);
            check(got_d[15:0] == e.bits[15:0], "R2", $sformatf("frame %0d tag (%s)", f, e.tag),
                  256'(got_d[15:0]), 256'(e.bits[15:0]));
            check(got_d[255:16] == e.bits[255:16], "R3", $sformatf("frame %0d slots (%s)", f, e.tag),
                  256'(got_d[255:16]), 256'(e.bits[255:16]));
            check(pops == e.pops, "R7", $sformatf("frame %0d pop count (%s)", f, e.tag),
                  256'(pops), 256'(e.pops));
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #4000000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule